// File: doc/BRIEF.md
# IDE PIO Cycle Timing Sequencer

This block turns one programmed-I/O request into the drive-side strobe sequence of an IDE cycle. All timing is counted in host bus clocks. A request carries the direction, a 3-bit register address, the chip-select choice, a transaction class, the target drive and that drive's IORDY mask. The request is latched, and the cycle then runs through four phases. Startup puts the address and select on the cable. In the strobe phase the read or write strobe goes low until the IORDY sample point. Recovery and shutdown follow, and during both the strobe is high while address and select remain valid.

The class selects the length of startup, of the strobe and of recovery from a built-in table. Shutdown always lasts two clocks. If IORDY is low at the sample point and the drive is not masked, the strobe is extended one clock at a time. For compatible classes, a legacy recovery-extension input adds extra recovery clocks. Read data is captured when the strobe ends. Completion is reported with a single-clock pulse.

Top module: `ide_pio_seq`

## Requirements
- R1: After reset, and whenever no cycle runs, both chip selects, both strobes and ready are at their idle levels: cs_n_o=2'b11, dior_n_o=1, diow_n_o=1, dd_oe_o=0 and ready_o=1.
- R2: Class code 0 (non-data compatible) and the spare code 3 give 4 startup clocks, a strobe of 11 clocks when IORDY is high, and 22 recovery clocks.
- R3: Class code 1 (data-port compatible) gives 3 startup clocks, an 11-free strobe of 6 clocks, and 14 recovery clocks.
- R4: Class code 2 (fast timing) gives 2 startup clocks, a strobe of 2 clocks and 1 recovery clock.
- R5: Every cycle ends with 2 shutdown clocks after recovery. From the first startup clock to the end of shutdown, da_o holds the request address and the selected chip select stays low: cs_sel_i=0 drives cs_n_o=2'b10 and cs_sel_i=1 drives cs_n_o=2'b01. The strobe is high throughout recovery and shutdown.
- R6: If IORDY is low at the sample point and the drive is unmasked, the strobe stays low and IORDY is sampled again on each following clock. Each low sample lengthens the strobe by exactly one clock.
- R7: When bit drive_i of iordy_mask_i is set, IORDY is treated as high at the first sample point. A mask bit that belongs to the other drive has no effect.
- R8: With rec16_en_i=1, classes 0, 1 and 3 get EXT_REC (default 4) extra recovery clocks. Class 2 gets none.
- R9: On a read, the value of dd_i at the clock edge that ends the strobe is held on rdata_o after completion.
- R10: A write drives diow_n_o and keeps dior_n_o high. dd_oe_o=1 and dd_o carries the request data from the first startup clock to the end of shutdown. A read keeps diow_n_o high and dd_oe_o low.
- R11: done_o is high for exactly one clock, the first clock after shutdown ends. ready_o is low from acceptance through that clock. A request presented during the busy or done clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, accepted when ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Drive register address |
| cs_sel_i | input | 1 | Chip-select choice (0: select 0, 1: select 1) |
| cls_i | input | 2 | Transaction class code |
| drive_i | input | 1 | Target drive |
| iordy_mask_i | input | 2 | Per-drive IORDY mask |
| rec16_en_i | input | 1 | Legacy recovery extension enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Captured read data |
| ready_o | output | 1 | Idle and able to accept |
| done_o | output | 1 | One-clock completion pulse |
| da_o | output | 3 | Drive address lines |
| cs_n_o | output | 2 | Chip selects, active low |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | DATA_W | Drive data out |
| dd_oe_o | output | 1 | Drive data output enable |
| dd_i | input | DATA_W | Drive data in |
| iordy_i | input | 1 | Drive ready |

## Verification
The assertions check invariants on every cycle:
- the strobes are never low together;
- a strobe never appears without a chip select;
- address and select do not move within a cycle;
- a write never overlaps the read strobe;
- done is a single pulse on an idle sequencer;
- an unready sample keeps the strobe phase.

Only the bench scenarios can show the exact phase lengths for each class, the recovery extension and its absence in fast timing, the per-drive mask, the captured read value, and that a request made during the done clock is dropped.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  typedef enum logic [1:0] {
    CLS_NDAT = 2'd0,
    CLS_DAT  = 2'd1,
    CLS_FAST = 2'd2,
    CLS_SPR  = 2'd3
  } xfer_cls_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOV,
    PH_HOLD
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
  import ide_pio_pkg::*;
#(
  parameter int SU_ND   = 4,
  parameter int SP_ND   = 11,
  parameter int RC_ND   = 22,
  parameter int SU_DP   = 3,
  parameter int SP_DP   = 6,
  parameter int RC_DP   = 14,
  parameter int SU_FT   = 2,
  parameter int SP_FT   = 2,
  parameter int RC_FT   = 1,
  parameter int SD_LEN  = 2,
  parameter int EXT_REC = 4,
  parameter int CNT_W   = 5
) (
  input  xfer_cls_e        cls_i,
  input  logic             rec16_en_i,
  output logic [CNT_W-1:0] su_len_o,
  output logic [CNT_W-1:0] sp_len_o,
  output logic [CNT_W-1:0] rc_len_o,
  output logic [CNT_W-1:0] sd_len_o
);
  logic [CNT_W-1:0] ext;

  // the legacy extension never applies to fast timing
  assign ext      = rec16_en_i ? CNT_W'(EXT_REC) : '0;
  assign sd_len_o = CNT_W'(SD_LEN);

  always_comb begin
    unique case (cls_i)
      CLS_DAT: begin
        su_len_o = CNT_W'(SU_DP);
        sp_len_o = CNT_W'(SP_DP);
        rc_len_o = CNT_W'(RC_DP) + ext;
      end
      CLS_FAST: begin
        su_len_o = CNT_W'(SU_FT);
        sp_len_o = CNT_W'(SP_FT);
        rc_len_o = CNT_W'(RC_FT);
      end
      default: begin
        su_len_o = CNT_W'(SU_ND);
        sp_len_o = CNT_W'(SP_ND);
        rc_len_o = CNT_W'(RC_ND) + ext;
      end
    endcase
  end
endmodule

// File: rtl/ide_pio_fsm.sv
module ide_pio_fsm
  import ide_pio_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rdy_i,
  input  logic [CNT_W-1:0] su_len_i,
  input  logic [CNT_W-1:0] sp_len_i,
  input  logic [CNT_W-1:0] rc_len_i,
  input  logic [CNT_W-1:0] sd_len_i,
  output phase_e           phase_o,
  output logic             strobe_end_o,
  output logic             done_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_len;
  logic             last;
  logic             done_q;

  always_comb begin
    unique case (phase_q)
      PH_SETUP:  cur_len = su_len_i;
      PH_STROBE: cur_len = sp_len_i;
      PH_RECOV:  cur_len = rc_len_i;
      PH_HOLD:   cur_len = sd_len_i;
      default:   cur_len = CNT_W'(1);
    endcase
  end

  assign last         = (cnt_q == cur_len - CNT_W'(1));
  assign strobe_end_o = (phase_q == PH_STROBE) && last && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= '0;
        end
        PH_SETUP: begin
          if (last) begin
            phase_q <= PH_STROBE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        PH_STROBE: begin
          // hold at the sample point until ready
          if (last) begin
            if (rdy_i) begin
              phase_q <= PH_RECOV;
              cnt_q   <= '0;
            end
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        PH_RECOV: begin
          if (last) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        PH_HOLD: begin
          if (last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R6
  strobe_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && last && !rdy_i) |=> phase_q == PH_STROBE);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> phase_q == PH_IDLE);
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SU_ND   = 4,
  parameter int SP_ND   = 11,
  parameter int RC_ND   = 22,
  parameter int SU_DP   = 3,
  parameter int SP_DP   = 6,
  parameter int RC_DP   = 14,
  parameter int SU_FT   = 2,
  parameter int SP_FT   = 2,
  parameter int RC_FT   = 1,
  parameter int SD_LEN  = 2,
  parameter int EXT_REC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic              cs_sel_i,
  input  logic [1:0]        cls_i,
  input  logic              drive_i,
  input  logic [1:0]        iordy_mask_i,
  input  logic              rec16_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              done_o,
  output logic [2:0]        da_o,
  output logic [1:0]        cs_n_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  input  logic [DATA_W-1:0] dd_i,
  input  logic              iordy_i
);
  localparam int MAXC = imax(imax(RC_ND, RC_DP) + EXT_REC,
                             imax(imax(SP_ND, SP_DP), imax(SU_ND, SD_LEN)));
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              wr_q, csel_q, mask_q, rec16_q;
  logic [2:0]        addr_q;
  logic [1:0]        cls_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  su_len, sp_len, rc_len, sd_len;
  phase_e            phase;
  logic              strobe_end, done, accept, busy, rdy_eff;

  assign ready_o = (phase == PH_IDLE) && !done;
  assign accept  = req_i && ready_o;
  assign busy    = (phase != PH_IDLE);
  assign rdy_eff = iordy_i || mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      csel_q  <= 1'b0;
      mask_q  <= 1'b0;
      rec16_q <= 1'b0;
      addr_q  <= '0;
      cls_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= wr_i;
      csel_q  <= cs_sel_i;
      mask_q  <= iordy_mask_i[drive_i];
      rec16_q <= rec16_en_i;
      addr_q  <= addr_i;
      cls_q   <= cls_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if (strobe_end && !wr_q) rdata_q <= dd_i;
  end

  ide_pio_timing #(
    .SU_ND(SU_ND), .SP_ND(SP_ND), .RC_ND(RC_ND),
    .SU_DP(SU_DP), .SP_DP(SP_DP), .RC_DP(RC_DP),
    .SU_FT(SU_FT), .SP_FT(SP_FT), .RC_FT(RC_FT),
    .SD_LEN(SD_LEN), .EXT_REC(EXT_REC), .CNT_W(CNT_W)
  ) u_timing (
    .cls_i      (xfer_cls_e'(cls_q)),
    .rec16_en_i (rec16_q),
    .su_len_o   (su_len),
    .sp_len_o   (sp_len),
    .rc_len_o   (rc_len),
    .sd_len_o   (sd_len)
  );

  ide_pio_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .rdy_i        (rdy_eff),
    .su_len_i     (su_len),
    .sp_len_i     (sp_len),
    .rc_len_i     (rc_len),
    .sd_len_i     (sd_len),
    .phase_o      (phase),
    .strobe_end_o (strobe_end),
    .done_o       (done)
  );

  assign done_o   = done;
  assign rdata_o  = rdata_q;
  assign da_o     = busy ? addr_q : '0;
  assign cs_n_o   = busy ? (csel_q ? 2'b01 : 2'b10) : 2'b11;
  assign dior_n_o = !((phase == PH_STROBE) && !wr_q);
  assign diow_n_o = !((phase == PH_STROBE) && wr_q);
  assign dd_oe_o  = busy && wr_q;
  assign dd_o     = dd_oe_o ? wdata_q : '0;

  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(da_o) && $stable(cs_n_o)));
  // R5
  strobe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_n_o || !diow_n_o) |-> cs_n_o != 2'b11);
  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dior_n_o || diow_n_o);
  // R10
  drive_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> dior_n_o);
  // R1
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_n_o == 2'b11 && dior_n_o && diow_n_o && !dd_oe_o));
endmodule

// File: tb/ide_pio_seq_bench.sv
module ide_pio_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0, cs_sel_i = 1'b0, drive_i = 1'b0;
  logic        rec16_en_i = 1'b0, iordy_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  cls_i = '0, iordy_mask_i = '0;
  logic [15:0] wdata_i = '0, dd_i = '0;
  logic [15:0] rdata_o, dd_o;
  logic        ready_o, done_o, dior_n_o, diow_n_o, dd_oe_o;
  logic [2:0]  da_o;
  logic [1:0]  cs_n_o;
  int total = 0, bad = 0, seed = 1;

  always #4 clk_i = ~clk_i;

  ide_pio_seq u_ide_pio_seq (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run(input int cls, input int wr, input int drv, input int mode, input int rec);
    int su_e, sp_e, rc_e, waitc, n_su, n_sp, n_tl, ph, pin_bad, ord_bad;
    logic [1:0] msk, exp_cs;
    logic [15:0] last_dd, wd;
    logic [2:0] ad;
    bit csel;
    su_e = (cls == 1) ? 3 : (cls == 2) ? 2 : 4;
    sp_e = (cls == 1) ? 6 : (cls == 2) ? 2 : 11;
    rc_e = (cls == 1) ? 14 : (cls == 2) ? 1 : 22;
    if (rec != 0 && cls != 2) rc_e += 4;
    msk   = (mode == 2) ? (drv ? 2'b10 : 2'b01) : (mode == 1) ? (drv ? 2'b01 : 2'b10) : 2'b00;
    waitc = (mode == 0) ? 0 : (mode == 1) ? 3 : 1000;
    csel  = 1'((cls + wr + mode) & 1);
    ad    = 3'((cls * 3 + wr + mode * 2 + 1) & 7);
    wd    = 16'(seed * 1237 + 5);
    exp_cs = csel ? 2'b01 : 2'b10;
    @(negedge clk_i);
    req_i = 1'b1; wr_i = 1'(wr); cls_i = 2'(cls); drive_i = 1'(drv);
    iordy_mask_i = msk; rec16_en_i = 1'(rec); cs_sel_i = csel; addr_i = ad;
    wdata_i = wd; iordy_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~ad; wdata_i = ~wd;
    n_su = 0; n_sp = 0; n_tl = 0; ph = 0; pin_bad = 0; ord_bad = 0; last_dd = '0;
    for (int k = 0; k < 300; k++) begin
      bit stb;
      if (cs_n_o == 2'b11) break;
      if (da_o != ad || cs_n_o != exp_cs || ready_o) pin_bad++;
      if (wr != 0 && (!dd_oe_o || dd_o != wd || !dior_n_o)) pin_bad++;
      if (wr == 0 && (dd_oe_o || !diow_n_o)) pin_bad++;
      // mid-cycle requests must be ignored
      req_i = (k == 1);
      stb = (wr != 0) ? !diow_n_o : !dior_n_o;
      if (stb) begin
        if (ph == 2) ord_bad++;
        ph = 1; n_sp++;
        iordy_i = (n_sp >= sp_e + waitc);
        seed++;
        dd_i = 16'(seed * 977 + n_sp);
        last_dd = dd_i;
      end else if (ph == 0) n_su++;
      else begin ph = 2; n_tl++; end
      @(negedge clk_i);
    end
    req_i = 1'b0;
    chk(pin_bad == 0, (wr != 0) ? "R10/R5 pins during cycle" : "R5 pins during cycle", pin_bad, 0);
    chk(ord_bad == 0, "R5 no strobe after recovery", ord_bad, 0);
    case (cls)
      1: chk(n_su == su_e, "R3 startup", n_su, su_e);
      2: chk(n_su == su_e, "R4 startup", n_su, su_e);
      default: chk(n_su == su_e, "R2 startup", n_su, su_e);
    endcase
    if (mode == 2)      chk(n_sp == sp_e, "R7 masked strobe", n_sp, sp_e);
    else if (mode == 1) chk(n_sp == sp_e + waitc, "R6 R7 extended strobe", n_sp, sp_e + waitc);
    else                chk(n_sp == sp_e, "R2 R3 R4 strobe", n_sp, sp_e);
    chk(n_tl == rc_e + 2, (rec != 0) ? "R8 recovery+shutdown" : "R5 recovery+shutdown", n_tl, rc_e + 2);
    chk(done_o == 1'b1, "R11 done after shutdown", int'(done_o), 1);
    chk(ready_o == 1'b0, "R11 not ready in done clock", int'(ready_o), 0);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(cs_n_o == 2'b11 && done_o == 1'b0 && ready_o, "R11 done-clock request ignored", int'(cs_n_o), 3);
    if (wr == 0) chk(rdata_o == last_dd, "R9 read capture", int'(rdata_o), int'(last_dd));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_n_o == 2'b11 && dior_n_o && diow_n_o && !dd_oe_o && ready_o && !done_o,
        "R1 reset idle", int'(cs_n_o), 3);
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 2; r++)
          for (int m = 0; m < 3; m++)
            run(c, w, (c + m) & 1, m, r);
    chk(cs_n_o == 2'b11 && dior_n_o && diow_n_o && !dd_oe_o && ready_o,
        "R1 idle after sweep", int'(cs_n_o), 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule